// File: doc/BRIEF.md
# Synchronous master serial receiver

This block receives serial words while acting as the clock master of a two-wire synchronous link. It generates the serial clock from a programmable divisor, captures the data line on each falling clock edge, and assembles words of 8 or 9 bits with the least significant bit first. Each finished word moves from the shift register into a two-entry holding queue. Every queue entry carries its own ninth bit and a width tag. An available flag tells software that data is waiting.

Software selects one of two receive styles. A single request takes exactly one word and then stops the clock. A continuous enable keeps receiving word after word, and it wins when both controls are set. If a word completes while the queue is full, the word is dropped. In continuous mode an overrun flag is also raised, and that flag blocks every later transfer until continuous receive is switched off. Dropping the port enable, or dropping both receive controls, returns the receive logic to idle and leaves the queued words in place.

Top module: `sync_rx_master`

## Requirements
- R1: While receiving, the serial clock has a period of 2*(divisor+1) system clocks. It is high for the first divisor+1 cycles and low for the rest, and it stays low when idle.
- R2: The data line is sampled at each falling clock edge, least significant bit first. An 8-bit word fills rd_data[7:0] and reports rd_bit9=0. In 9-bit mode (nine_bit=1) the ninth bit, which is shifted in last, appears on rd_bit9.
- R3: Raising single_req (with cont_en low) produces exactly one word's worth of clock pulses and then the clock stops. No further word starts until single_req has been low and is raised again.
- R4: With cont_en high, words are received back to back with no gap. With both single_req and cont_en high, reception continues past the first word.
- R5: Completed words enter a two-entry first-in first-out queue. rx_avail is high while the queue is non-empty, and it drops once reads have emptied the queue. A read is a one-cycle rd_strobe.
- R6: A word that completes while the queue holds two entries is discarded. If cont_en is high, overrun is set. If cont_en is low, overrun stays low.
- R7: While overrun is set, no completed word enters the queue, even after a read has made room. overrun stays set until cont_en is low, and it is clear the cycle after.
- R8: Each queue entry keeps its own ninth bit and width tag (rd_wide=1 for a 9-bit word). A read advances rd_data, rd_bit9 and rd_wide together to the next entry.
- R9: Dropping port_en, or dropping both receive controls, stops the clock by the next cycle and discards any partial word. Queued words are kept, and a later word is received correctly from its first bit.
- R10: When the queue is empty, rd_data, rd_bit9 and rd_wide are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Serial port enable |
| single_req | input | 1 | Single-word receive request |
| cont_en | input | 1 | Continuous receive enable |
| nine_bit | input | 1 | 1 selects 9-bit words |
| divisor | input | DIV_W | Clock divisor; half period is divisor+1 cycles |
| sdata_in | input | 1 | Serial data line |
| rd_strobe | input | 1 | One-cycle read of the queue head |
| sclk_out | output | 1 | Generated serial clock |
| rd_data | output | 8 | Low eight bits of the queue head |
| rd_bit9 | output | 1 | Ninth bit of the queue head |
| rd_wide | output | 1 | Queue head was received as a 9-bit word |
| rx_avail | output | 1 | Queue holds at least one word |
| overrun | output | 1 | Overrun flag |

## Verification
The properties assume that divisor and nine_bit do not change while a word is being received. They also assume that rd_strobe is never asserted in the same cycle that a word completes into a full queue. The stimulus changes the divisor and the width only while the clock is stopped. It issues every read a known number of cycles after a counted falling edge, well away from the next word boundary. The serial data is driven by a model slave that presents each new bit just after every rising edge of the generated clock. That way each falling-edge sample sees a line that has been stable for half a period.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;

  typedef struct packed {
    logic       wide;
    logic [8:0] word;
  } rx_entry_t;

  function automatic logic [3:0] last_bit_index(input logic wide);
    return wide ? 4'd8 : 4'd7;
  endfunction

  function automatic logic [8:0] merge_bit(input logic [8:0] acc, input logic b,
                                           input logic [3:0] pos);
    return acc | (9'(b) << pos);
  endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             fall_evt,
  output logic             end_evt
);
  logic [DIV_W-1:0] cnt;
  logic             low_half;
  logic             tick;

  assign tick     = run && (cnt == div);
  assign fall_evt = tick && !low_half;
  assign end_evt  = tick && low_half;
  assign sclk     = run && !low_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      low_half <= 1'b0;
    end else if (!run) begin
      cnt      <= '0;
      low_half <= 1'b0;
    end else if (tick) begin
      cnt      <= '0;
      low_half <= !low_half;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/srx_shift.sv
module srx_shift
  import sync_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clear,
  input  logic      sample,
  input  logic      sdata,
  input  logic      nine_bit,
  output logic      done_evt,
  output logic [3:0] bit_idx,
  output rx_entry_t word_out
);
  logic [8:0] sh;
  logic [3:0] idx;
  logic       wide_q;
  logic       wide_eff;

  assign wide_eff      = (idx == 4'd0) ? nine_bit : wide_q;
  assign done_evt      = sample && (idx == last_bit_index(wide_eff));
  assign bit_idx       = idx;
  assign word_out.word = merge_bit(sh, sdata, idx);
  assign word_out.wide = wide_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      idx    <= '0;
      wide_q <= 1'b0;
    end else begin
      wide_q <= wide_eff;
      if (clear) begin
        sh  <= '0;
        idx <= '0;
      end else if (sample) begin
        if (done_evt) begin
          sh  <= '0;
          idx <= '0;
        end else begin
          sh[idx] <= sdata;
          idx     <= idx + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
  import sync_rx_pkg::*;
#(
  parameter  int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  rx_entry_t        wr_entry,
  input  logic             pop,
  output rx_entry_t        head,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  rx_entry_t        mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full = (count == CNT_W'(DEPTH));
  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end
endmodule

// File: rtl/sync_rx_master.sv
module sync_rx_master
  import sync_rx_pkg::*;
#(
  parameter  int DIV_W = 8,
  parameter  int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             single_req,
  input  logic             cont_en,
  input  logic             nine_bit,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sdata_in,
  input  logic             rd_strobe,
  output logic             sclk_out,
  output logic [7:0]       rd_data,
  output logic             rd_bit9,
  output logic             rd_wide,
  output logic             rx_avail,
  output logic             overrun
);
  logic             active;
  logic             single_done;
  logic             run_req;
  logic             abort;
  logic             ev_fall;
  logic             ev_end;
  logic             ev_done;
  logic             ev_push;
  logic             ev_pop;
  logic             ev_ovf;
  logic             word_end;
  logic             fifo_full;
  logic [3:0]       bit_idx;
  logic [CNT_W-1:0] fifo_count;
  rx_entry_t        shifted;
  rx_entry_t        head;

  assign abort    = !port_en || (!single_req && !cont_en);
  assign run_req  = port_en && (cont_en || (single_req && !single_done));
  assign word_end = ev_end && (bit_idx == 4'd0);
  assign ev_push  = ev_done && !overrun && !fifo_full;
  assign ev_ovf   = ev_done && fifo_full && cont_en;
  assign ev_pop   = rd_strobe && rx_avail;
  assign rx_avail = (fifo_count != '0);
  assign rd_data  = rx_avail ? head.word[7:0] : 8'h00;
  assign rd_bit9  = rx_avail && head.word[8];
  assign rd_wide  = rx_avail && head.wide;

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (active),
    .div      (divisor),
    .sclk     (sclk_out),
    .fall_evt (ev_fall),
    .end_evt  (ev_end)
  );

  srx_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (!active),
    .sample   (ev_fall),
    .sdata    (sdata_in),
    .nine_bit (nine_bit),
    .done_evt (ev_done),
    .bit_idx  (bit_idx),
    .word_out (shifted)
  );

  srx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ev_push),
    .wr_entry (shifted),
    .pop      (ev_pop),
    .head     (head),
    .count    (fifo_count),
    .full     (fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (!active) begin
      active <= run_req;
    end else if (word_end && !run_req) begin
      active <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      single_done <= 1'b0;
    else if (!single_req)            single_done <= 1'b0;
    else if (ev_done && !cont_en)    single_done <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        overrun <= 1'b0;
    else if (!cont_en) overrun <= 1'b0;
    else if (ev_ovf)   overrun <= 1'b1;
  end
endmodule

// File: rtl/sync_rx_master_chk.sv
module sync_rx_master_chk #(
  parameter int DEPTH = 2,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_en,
  input logic             cont_en,
  input logic             sclk_out,
  input logic             ev_fall,
  input logic             ev_done,
  input logic             ev_push,
  input logic             ev_pop,
  input logic [CNT_W-1:0] fifo_count,
  input logic             overrun,
  input logic             rx_avail
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH)); // R5

  AST_AVAIL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_pop && fifo_count == CNT_W'(1) && !ev_push) |=> !rx_avail); // R5

  AST_SAMPLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> !sclk_out); // R2

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sclk_out); // R9

  AST_FULL_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && fifo_count == CNT_W'(DEPTH)) |-> !ev_push); // R6

  AST_OVR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> !ev_push); // R7

  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && cont_en) |=> overrun); // R7

  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cont_en |=> !overrun); // R7
endmodule

bind sync_rx_master sync_rx_master_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_en    (port_en),
  .cont_en    (cont_en),
  .sclk_out   (sclk_out),
  .ev_fall    (ev_fall),
  .ev_done    (ev_done),
  .ev_push    (ev_push),
  .ev_pop     (ev_pop),
  .fifo_count (fifo_count),
  .overrun    (overrun),
  .rx_avail   (rx_avail)
);

// File: tb/sim_sync_rx_master.sv
module sim_sync_rx_master;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_en = 1'b0;
  logic       single_req = 1'b0;
  logic       cont_en = 1'b0;
  logic       nine_bit = 1'b0;
  logic [7:0] divisor = 8'd0;
  logic       sdata_in = 1'b0;
  logic       rd_strobe = 1'b0;
  logic       sclk_out;
  logic [7:0] rd_data;
  logic       rd_bit9;
  logic       rd_wide;
  logic       rx_avail;
  logic       overrun;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // model slave state (owned by the always block below)
  int   rises = 0;
  int   falls = 0;
  int   rise_cyc = 0;
  int   period_meas = 0;
  int   high_meas = 0;
  logic sclk_prev = 1'b0;
  // stimulus state (owned by the initial block)
  logic [63:0] stream = '0;
  int          base = 0;

  sync_rx_master u0 (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_req(single_req),
    .cont_en(cont_en), .nine_bit(nine_bit), .divisor(divisor),
    .sdata_in(sdata_in), .rd_strobe(rd_strobe), .sclk_out(sclk_out),
    .rd_data(rd_data), .rd_bit9(rd_bit9), .rd_wide(rd_wide),
    .rx_avail(rx_avail), .overrun(overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    sclk_prev <= sclk_out;
    if (sclk_out && !sclk_prev) begin
      int k;
      k = rises - base;
      sdata_in    <= (k >= 0 && k < 64) ? stream[k] : 1'b0;
      rises       <= rises + 1;
      period_meas <= cyc - rise_cyc;
      rise_cyc    <= cyc;
    end
    if (!sclk_out && sclk_prev) begin
      falls     <= falls + 1;
      high_meas <= cyc - rise_cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(input logic [8:0] w0, input logic [8:0] w1,
                      input logic [8:0] w2, input logic [8:0] w3, input int nb);
    logic [63:0] s;
    logic [8:0]  mask;
    mask = (nb == 9) ? 9'h1FF : 9'h0FF;
    s = 64'(w0 & mask) | (64'(w1 & mask) << nb) | (64'(w2 & mask) << (2*nb))
      | (64'(w3 & mask) << (3*nb));
    stream = s;
    base   = rises;
  endtask

  task automatic wait_falls(input int target);
    while (falls < target) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic head_is(input string req, input logic [8:0] w, input int wide);
    chk(req, int'(rx_avail), 1);
    chk(req, int'(rd_data), int'(w[7:0]));
    chk(req, int'(rd_bit9), wide ? int'(w[8]) : 0);
    chk(req, int'(rd_wide), wide);
  endtask

  task automatic single_word(input int d, input int wide, input logic [8:0] w,
                             input bit do_rd);
    int nb, f0, r0;
    nb = wide ? 9 : 8;
    @(negedge clk);
    divisor  = 8'(d);
    nine_bit = wide[0];
    load(w, 9'h0, 9'h0, 9'h0, nb);
    f0 = falls; r0 = rises;
    single_req = 1'b1;
    wait_falls(f0 + nb);
    tick(2*(d+1) + 8);
    chk("R3 clock pulses per single word", rises - r0, nb);
    chk("R3 clock stopped", int'(sclk_out), 0);
    chk("R1 period", period_meas, 2*(d+1));
    chk("R1 high time", high_meas, d+1);
    if (do_rd) begin
      head_is("R2 R8 word", w, wide);
      do_read();
      chk("R5 avail cleared", int'(rx_avail), 0);
      chk("R10 empty data", int'({rd_data, rd_bit9, rd_wide}), 0);
    end
    single_req = 1'b0;
    tick(2);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk("R1 reset sclk", int'(sclk_out), 0);
    chk("R5 reset avail", int'(rx_avail), 0);
    chk("R7 reset overrun", int'(overrun), 0);
    chk("R10 reset data", int'({rd_data, rd_bit9, rd_wide}), 0);
    port_en = 1'b1;
    tick(4);
    chk("R3 no clock without request", rises, 0);

    // sweep of divisor, width and word patterns in single mode
    for (int d = 0; d < 4; d++)
      for (int wd = 0; wd < 2; wd++)
        for (int k = 0; k < 3; k++)
          single_word(d, wd, 9'((d*37 + wd*101 + k*173 + 5) * 3), 1'b1);

    // R8: per-entry width tag and ninth bit advance on read
    single_word(1, 0, 9'h0A7, 1'b0);
    single_word(1, 1, 9'h15C, 1'b0);
    head_is("R8 first entry", 9'h0A7, 0);
    do_read();
    head_is("R8 second entry", 9'h15C, 1);
    do_read();
    chk("R5 empty after two reads", int'(rx_avail), 0);

    // continuous mode, overrun and blocking
    @(negedge clk);
    divisor = 8'd1; nine_bit = 1'b1;
    load(9'h1C3, 9'h03C, 9'h155, 9'h0AA, 9);
    begin
      int f0;
      f0 = falls;
      cont_en = 1'b1;
      wait_falls(f0 + 27);
      tick(2);
      chk("R6 overrun on third word", int'(overrun), 1);
      head_is("R5 R8 cont head A", 9'h1C3, 1);
      do_read();
      head_is("R8 cont head B", 9'h03C, 1);
      chk("R7 overrun held after read", int'(overrun), 1);
      wait_falls(f0 + 36);
      tick(2);
      chk("R4 continuous clocking", int'(rises - base >= 36), 1);
      do_read();
      chk("R7 transfer blocked while overrun", int'(rx_avail), 0);
      chk("R7 overrun still set", int'(overrun), 1);
      cont_en = 1'b0;
      tick(2);
      chk("R7 overrun cleared by cont off", int'(overrun), 0);
      chk("R9 clock stops on both off", int'(sclk_out), 0);
    end

    // R4 precedence, then R6 discard in single mode with full queue
    @(negedge clk);
    divisor = 8'd0; nine_bit = 1'b0;
    load(9'h05A, 9'h0E1, 9'h033, 9'h0FF, 8);
    begin
      int f0;
      f0 = falls;
      single_req = 1'b1; cont_en = 1'b1;
      wait_falls(f0 + 16);
      tick(2);
      chk("R4 continuous wins over single", int'(sclk_out || rises - base > 16), 1);
      single_req = 1'b0; cont_en = 1'b0;
      tick(10);
      chk("R4 two words queued", int'(rx_avail), 1);
    end
    single_word(2, 0, 9'h0C9, 1'b0);
    chk("R6 no overrun in single mode", int'(overrun), 0);
    head_is("R6 head kept", 9'h05A, 0);
    do_read();
    head_is("R6 second kept", 9'h0E1, 0);
    do_read();
    chk("R6 extra word discarded", int'(rx_avail), 0);

    // R9 abort mid-word, then a clean word
    @(negedge clk);
    divisor = 8'd2; nine_bit = 1'b0;
    load(9'h0FF, 9'h0, 9'h0, 9'h0, 8);
    begin
      int f0, r1;
      f0 = falls;
      single_req = 1'b1;
      wait_falls(f0 + 3);
      port_en = 1'b0;
      tick(1);
      chk("R9 clock low after disable", int'(sclk_out), 0);
      r1 = rises;
      tick(20);
      chk("R9 no clock while disabled", rises - r1, 0);
      chk("R9 partial word dropped", int'(rx_avail), 0);
      single_req = 1'b0;
      tick(2);
      port_en = 1'b1;
    end
    single_word(2, 0, 9'h012, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule